// File: doc/BRIEF.md
# Digital Input Debounce Filter Bank

This block cleans up groups of slow digital input lines before the rest of the chip uses them. The lines are arranged in ports of eight. Each line has an enable bit. A line with its filter enabled changes its output only after the raw level has stayed at a new value for a programmed stability time. A line with its filter disabled passes its synchronised raw level straight to the output.

All filtered lines share one stability interval, counted in 200 ns ticks. A prescaler derives the ticks from the system clock, whose frequency is a parameter. Software sets up the block through a byte-wide write port. One register holds the shared interval, and each port has its own 8-bit enable mask. Every raw line first passes through a two-flop synchroniser, whether or not its filter is enabled.

Top module: `digital_glitch_filter`

## Requirements
- R1: While `rst` is high, every `filt_o` bit is 0, every enable bit is cleared and the interval is 0. After reset is released, every line therefore behaves as a pass-through.
- R2: A byte written to address 0x44 + 16·p, for p below NUM_PORTS, becomes the enable mask of port p. Bit n of that byte enables the filter of line 8·p + n. A write to any other address, apart from those in R3, changes no mask.
- R3: The interval is a 32-bit little-endian value held in bytes 0x08 (bits 7:0), 0x09, 0x0A and 0x0B (bits 31:24). It is counted in 200 ns ticks.
- R4: If the stored 32-bit value is above 0xFFFFF, the block uses 0xFFFFF. The upper bits are not truncated away.
- R5: One tick occurs every CLK_HZ / 5,000,000 clock cycles, which is 200 ns.
- R6: A line whose enable bit is 0 drives `filt_o` with its raw level delayed by exactly two clock edges.
- R7: Take an enabled line with interval N > 0, where T is the number of cycles per tick. If its raw level changes and then holds, `filt_o` takes the new level at a clock edge between 3 + (N−1)·T and 2 + N·T edges after the change.
- R8: On an enabled line with interval N > 0, a raw excursion lasting at most (N−1)·T cycles never reaches `filt_o`. A return to the current output level restarts the count.
- R9: An enabled line with interval 0 behaves like a disabled line: a delay of exactly two edges.
- R10: The one interval applies to enabled lines on every port. Each line keeps its own count, so lines do not disturb one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write data |
| raw_i | input | 8·NUM_PORTS | Asynchronous raw input lines |
| filt_o | output | 8·NUM_PORTS | Filtered or passed-through lines |

## Verification
A wrong stability count or tick rate shows up as an output transition that falls outside the R7 latency window. That window is one tick wide, so an error of even one cycle per tick is caught within a few hundred cycles of a single change. A corrupted mask or a wrong address decode shows up two edges after the next raw change: a line is either delayed where it should pass through, or passes through where it should hold. A saturation fault takes longer to reveal. It appears only when an over-range interval lets a pulse through that should have been held, which the bench arranges with a value whose low 20 bits are small.

// File: rtl/dfb_pkg.sv
package dfb_pkg;
   localparam int unsigned IVAL_W        = 20;
   localparam logic [IVAL_W-1:0] IVAL_MAX = 20'hFFFFF;
   localparam int unsigned ADDR_W        = 8;
   localparam int unsigned LINES_PER_PORT = 8;
   localparam int unsigned MAX_PORTS     = 12;
   localparam logic [ADDR_W-1:0] IVAL_ADDR = 8'h08;
   localparam int unsigned MASK_BASE     = 'h44;
   localparam int unsigned MASK_STRIDE   = 16;
   localparam int unsigned TICK_RATE_HZ  = 5_000_000;
endpackage

// File: rtl/dfb_tick.sv
module dfb_tick #(
   parameter int unsigned CLK_HZ = 125_000_000
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   import dfb_pkg::*;
   localparam int unsigned DIV = CLK_HZ / TICK_RATE_HZ;
   localparam int unsigned CW  = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV <= 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst) begin
               cnt <= '0;
            end else if (cnt == CW'(DIV - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign tick_o = (cnt == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/dfb_regs.sv
module dfb_regs #(
   parameter int unsigned NUM_PORTS = 12
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        wr_en,
   input  logic [dfb_pkg::ADDR_W-1:0]  wr_addr,
   input  logic [7:0]                  wr_data,
   output logic [NUM_PORTS*8-1:0]      en_mask_o,
   output logic [dfb_pkg::IVAL_W-1:0]  ival_o
);
   import dfb_pkg::*;
   logic [31:0] ival_raw;

   genvar b, p;
   generate
      for (b = 0; b < 4; b++) begin : g_ival_byte
         always_ff @(posedge clk) begin
            if (rst) begin
               ival_raw[b*8 +: 8] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(IVAL_ADDR + b)) begin
               ival_raw[b*8 +: 8] <= wr_data;
            end
         end
      end
      for (p = 0; p < NUM_PORTS; p++) begin : g_mask
         always_ff @(posedge clk) begin
            if (rst) begin
               en_mask_o[p*8 +: 8] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(MASK_BASE + MASK_STRIDE*p)) begin
               en_mask_o[p*8 +: 8] <= wr_data;
            end
         end
      end
   endgenerate

   // saturate rather than truncate an over-range request
   assign ival_o = (ival_raw[31:IVAL_W] != '0) ? IVAL_MAX : ival_raw[IVAL_W-1:0];
endmodule

// File: rtl/dfb_line.sv
module dfb_line #(
   parameter int unsigned IVAL_W = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              raw,
   input  logic              en,
   input  logic [IVAL_W-1:0] ival,
   output logic              out
);
   logic s1, s2, held;
   logic [IVAL_W-1:0] cnt;
   logic bypass;

   assign bypass = !en || (ival == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         s1   <= 1'b0;
         s2   <= 1'b0;
         held <= 1'b0;
         cnt  <= '0;
      end else begin
         s1 <= raw;
         s2 <= s1;
         if (bypass) begin
            held <= s2;
            cnt  <= '0;
         end else if (s2 == held) begin
            cnt <= '0;
         end else if (tick) begin
            if (({1'b0, cnt} + 1'b1) >= {1'b0, ival}) begin
               held <= s2;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign out = bypass ? s2 : held;
endmodule

// File: rtl/digital_glitch_filter.sv
module digital_glitch_filter #(
   parameter int unsigned NUM_PORTS = 12,
   parameter int unsigned CLK_HZ    = 125_000_000
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic [7:0]             wr_addr,
   input  logic [7:0]             wr_data,
   input  logic [NUM_PORTS*8-1:0] raw_i,
   output logic [NUM_PORTS*8-1:0] filt_o
);
   import dfb_pkg::*;
   localparam int unsigned LINES = NUM_PORTS * LINES_PER_PORT;

   generate
      if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
         $error("NUM_PORTS out of range");
      end
      if (CLK_HZ % TICK_RATE_HZ != 0) begin : g_bad_clk
         $error("CLK_HZ must be a multiple of the tick rate");
      end
   endgenerate

   logic              tick;
   logic [LINES-1:0]  en_mask;
   logic [IVAL_W-1:0] ival;

   dfb_tick #(.CLK_HZ(CLK_HZ)) u_tick (
      .clk(clk), .rst(rst), .tick_o(tick)
   );

   dfb_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .en_mask_o(en_mask), .ival_o(ival)
   );

   genvar i;
   generate
      for (i = 0; i < LINES; i++) begin : g_line
         dfb_line #(.IVAL_W(IVAL_W)) u_line (
            .clk(clk), .rst(rst), .tick(tick), .raw(raw_i[i]),
            .en(en_mask[i]), .ival(ival), .out(filt_o[i])
         );
      end
   endgenerate
endmodule

// File: rtl/dfb_checker.sv
module dfb_checker #(
   parameter int unsigned NUM_PORTS = 12,
   parameter int unsigned CLK_HZ    = 125_000_000
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   tick,
   input logic [NUM_PORTS*8-1:0] en_mask,
   input logic [19:0]            ival,
   input logic [NUM_PORTS*8-1:0] raw_i,
   input logic [NUM_PORTS*8-1:0] filt_o
);
   localparam int unsigned DIV   = CLK_HZ / 5_000_000;
   localparam int unsigned LINES = NUM_PORTS * 8;

   logic [1:0]  since_rst;
   logic [31:0] gap;
   logic        seen_tick;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst <= '0;
         gap       <= '0;
         seen_tick <= 1'b0;
      end else begin
         if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
         if (tick) begin
            gap       <= '0;
            seen_tick <= 1'b1;
         end else begin
            gap <= gap + 1'b1;
         end
      end
   end

   // R1: reset clears outputs and configuration
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (filt_o == '0 && en_mask == '0 && ival == '0));

   // R5: ticks are evenly spaced
   assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (rst)
      (tick && seen_tick) |-> (gap == 32'(DIV - 1)));

   genvar i;
   generate
      for (i = 0; i < LINES; i++) begin : g_chk
         // R6 and R9: bypassed lines show the raw level two edges late
         assert_bypass_delay_R6: assert property (@(posedge clk) disable iff (rst)
            (since_rst == 2'd3 && (!en_mask[i] || ival == '0))
            |-> (filt_o[i] == $past(raw_i[i], 2)));
         // R7: a filtered line only moves at a tick edge
         assert_filtered_moves_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
            (since_rst != 2'd0 && en_mask[i] && ival != '0 &&
             $past(en_mask[i]) && $past(ival) != '0 && !$past(tick))
            |-> $stable(filt_o[i]));
      end
   endgenerate
endmodule

bind digital_glitch_filter dfb_checker #(.NUM_PORTS(NUM_PORTS), .CLK_HZ(CLK_HZ)) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .en_mask(en_mask), .ival(ival),
   .raw_i(raw_i), .filt_o(filt_o)
);

// File: tb/digital_glitch_filter_bench.sv
module digital_glitch_filter_bench;
   localparam int unsigned NP = 12;
   localparam int unsigned NL = NP * 8;
   localparam int unsigned T  = 25;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [NL-1:0] raw_i = '0;
   logic [NL-1:0] filt_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   digital_glitch_filter #(.NUM_PORTS(NP), .CLK_HZ(125_000_000)) u_digital_glitch_filter (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .raw_i(raw_i), .filt_o(filt_o)
   );

   function automatic int lat_lo(int n); return 3 + (n - 1) * T; endfunction
   function automatic int lat_hi(int n); return 2 + n * T; endfunction
   function automatic logic [7:0] mask_addr(int p); return 8'(8'h44 + 16 * p); endfunction

   task automatic chk(bit ok, string req, logic [NL-1:0] act, logic [NL-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_ival(logic [31:0] v);
      for (int b = 0; b < 4; b++) wr(8'(8'h08 + b), v[b*8 +: 8]);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // drives one line and returns the edge count until the output follows
   task automatic measure(int ln, logic v, int limit, output int k);
      @(negedge clk);
      raw_i[ln] = v;
      k = 0;
      for (int c = 1; c <= limit; c++) begin
         @(negedge clk);
         if (filt_o[ln] == v) begin k = c; break; end
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int k, k2;
      logic [NL-1:0] mask, h1, h2, nv;
      void'($urandom(32'd20240611));

      // R1: outputs held at zero during reset
      raw_i = '1;
      idle(4);
      chk(filt_o == '0, "R1 reset output", filt_o, '0);
      raw_i = '0;
      idle(2);
      rst = 1'b0;
      idle(3);

      // R1/R6: default state passes through with two-edge delay
      @(negedge clk); raw_i[17] = 1'b1;
      @(negedge clk);
      chk(filt_o[17] == 1'b0, "R6 one edge still old", filt_o, '0);
      @(negedge clk);
      chk(filt_o[17] == 1'b1, "R1 R6 pass-through after reset", filt_o, NL'(1) << 17);
      raw_i[17] = 1'b0; idle(3);

      // R7: enable line 2 of port 0, interval 4
      set_ival(32'd4);
      wr(mask_addr(0), 8'h04);
      measure(2, 1'b1, 400, k);
      chk(k >= lat_lo(4) && k <= lat_hi(4), "R7 latency N=4 rise", NL'(k), NL'(lat_lo(4)));
      measure(2, 1'b0, 400, k);
      chk(k >= lat_lo(4) && k <= lat_hi(4), "R7 latency N=4 fall", NL'(k), NL'(lat_lo(4)));

      // R5: longer interval narrows the window around the tick rate
      set_ival(32'd8);
      measure(2, 1'b1, 400, k);
      chk(k >= lat_lo(8) && k <= lat_hi(8), "R5 R7 latency N=8", NL'(k), NL'(lat_lo(8)));
      measure(2, 1'b0, 400, k);
      set_ival(32'd4);

      // R8: short pulse never reaches the output
      @(negedge clk); raw_i[2] = 1'b1;
      k = 0;
      for (int c = 0; c < 3 * T; c++) begin
         @(negedge clk); if (filt_o[2]) k = 1;
      end
      raw_i[2] = 1'b0;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk); if (filt_o[2]) k = 1;
      end
      chk(k == 0, "R8 glitch suppressed", NL'(k), '0);

      // R8: a one-cycle return to the old level restarts the count
      k = 0;
      @(negedge clk); raw_i[2] = 1'b1;
      for (int c = 0; c < 60; c++) begin @(negedge clk); if (filt_o[2]) k = 1; end
      raw_i[2] = 1'b0;
      @(negedge clk); if (filt_o[2]) k = 1;
      raw_i[2] = 1'b1;
      for (int c = 0; c < 60; c++) begin @(negedge clk); if (filt_o[2]) k = 1; end
      chk(k == 0, "R8 restart on return", NL'(k), '0);
      for (int c = 0; c < 200; c++) begin @(negedge clk); if (filt_o[2]) k = 1; end
      chk(k == 1, "R8 steady level accepted", NL'(k), NL'(1));
      raw_i[2] = 1'b0; idle(200);

      // R10: shared interval applies on first and last port
      set_ival(32'd3);
      wr(mask_addr(NP - 1), 8'h80);
      @(negedge clk); raw_i[0] = 1'b1; raw_i[NL-1] = 1'b1;
      k = 0; k2 = 0;
      for (int c = 1; c <= 300; c++) begin
         @(negedge clk);
         if (k  == 0 && filt_o[0])    k  = c;
         if (k2 == 0 && filt_o[NL-1]) k2 = c;
      end
      chk(k == 2, "R10 line 0 unaffected", NL'(k), NL'(2));
      chk(k2 >= lat_lo(3) && k2 <= lat_hi(3), "R10 R2 last port filtered", NL'(k2), NL'(lat_lo(3)));
      raw_i[0] = 1'b0; raw_i[NL-1] = 1'b0; idle(200);

      // R9: interval zero turns enabled lines into plain synchronisers
      set_ival(32'd0);
      measure(NL - 1, 1'b1, 50, k);
      chk(k == 2, "R9 interval zero", NL'(k), NL'(2));
      raw_i[NL-1] = 1'b0; idle(3);

      // R2: writes to non-mask addresses leave port 0 unfiltered
      wr(mask_addr(0), 8'h00);
      set_ival(32'd4);
      wr(8'h45, 8'hFF);
      wr(8'h34, 8'hFF);
      wr(8'h40, 8'hFF);
      measure(1, 1'b1, 50, k);
      chk(k == 2, "R2 stray writes ignored", NL'(k), NL'(2));
      raw_i[1] = 1'b0; idle(3);

      // R3 R4: just above the limit saturates, not truncates to zero
      wr(mask_addr(3), 8'h08);
      set_ival(32'h0010_0000);
      @(negedge clk); raw_i[27] = 1'b1;
      k = 0;
      for (int c = 0; c < 3000; c++) begin @(negedge clk); if (filt_o[27]) k = 1; end
      chk(k == 0, "R4 saturate 0x100000", NL'(k), '0);
      // R3: byte lanes assemble little-endian; 0x00100003 would truncate to 3
      set_ival(32'h0010_0003);
      k = 0;
      for (int c = 0; c < 3000; c++) begin @(negedge clk); if (filt_o[27]) k = 1; end
      chk(k == 0, "R4 saturate 0x100003", NL'(k), '0);
      // R3: low byte alone gives a short interval
      set_ival(32'h0000_0003);
      k = 0;
      for (int c = 1; c <= 300; c++) begin @(negedge clk); if (k == 0 && filt_o[27]) k = c; end
      chk(k != 0 && k <= lat_hi(3), "R3 byte order", NL'(k), NL'(lat_hi(3)));
      raw_i[27] = 1'b0; idle(200);

      // R6 R2 R10: random masks, random raw traffic, interval 5
      set_ival(32'd5);
      mask = '0;
      for (int p = 0; p < NP; p++) begin
         mask[p*8 +: 8] = 8'($urandom);
         wr(mask_addr(p), mask[p*8 +: 8]);
      end
      idle(200);
      h1 = raw_i; h2 = raw_i;
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         if (c >= 2) begin
            chk((filt_o & ~mask) == (h2 & ~mask), "R6 random pass-through",
                filt_o & ~mask, h2 & ~mask);
            chk((filt_o & mask) == '0, "R8 random toggles held",
                filt_o & mask, '0);
         end
         nv = {$urandom, $urandom, $urandom};
         raw_i = nv;
         h2 = h1; h1 = nv;
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule